// File: doc/BRIEF.md
# Scalar-Memory Clause Break Detector

This block follows the run of back-to-back scalar memory instructions that have most recently issued. Because members of such a run may finish out of order or be issued again, no register that any member writes may also be read by any member, and that includes an instruction reading its own destination. The block keeps the union of all registers written and the union of all registers read across the current run. A scheduler can offer a new scalar memory instruction as a candidate. One cycle later the block says whether that candidate would make the run unsafe, in which case some other instruction must be placed in between.

Issued instructions arrive on a strobe with a class code and two register bitmaps. A scalar memory issue extends the run. A no-op or any other class ends the run and empties both unions. A cycle with no issue strobe leaves the run as it is. The candidate is judged against the unions as they stand before any issue in the same cycle. The check applies only in the newer-generation mode. In the older mode it always answers zero.

Top module: `smem_clause_breaker`

## Requirements
- R1: After reset both clause unions are empty and `brk_req` is 0. A candidate offered right after reset therefore gets 0.
- R2: `issue_cls` encodes 2'b00 = no-op, 2'b01 = scalar memory, 2'b10 and 2'b11 = other. On a scalar memory issue, `issue_rd` and `issue_wr` are ORed into the clause read and write unions.
- R3: An issue of class no-op or other clears both unions. A following candidate is then judged against an empty run.
- R4: While the clause write union is zero, the answer is 0. This holds for stores, for candidates with register overlaps, and for clauses with reads only.
- R5: A candidate with `cand_store`=1 gets 1 when the clause write union is non-zero.
- R6: Otherwise, the clause unions are merged with the candidate's bitmaps. The answer is 1 when the merged write set ANDed with the merged read set is non-zero. Bit k of each bitmap stands for register k, bits 0 and 63 included. A self-overlap within the clause or within the candidate counts.
- R7: When the clause write union is non-zero, the candidate is a load, and the merged sets are disjoint, the answer is 0.
- R8: When `mode_new` is 0 in the candidate's cycle, the answer is 0.
- R9: `brk_req` is registered. It reflects the candidate presented with `cand_valid` in the previous cycle and is 0 after a cycle without a candidate. An issue in the same cycle as the candidate does not affect that answer.
- R10: Cycles with `issue_valid`=0 leave both unions unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_new | input | 1 | 1 enables the check (newer-generation mode) |
| issue_valid | input | 1 | An instruction issued this cycle |
| issue_cls | input | 2 | Class of the issued instruction |
| issue_rd | input | 64 | Registers read by the issued instruction |
| issue_wr | input | 64 | Registers written by the issued instruction |
| cand_valid | input | 1 | A candidate scalar memory instruction is offered |
| cand_store | input | 1 | The candidate is a store |
| cand_rd | input | 64 | Registers the candidate reads |
| cand_wr | input | 64 | Registers the candidate writes |
| brk_req | output | 1 | 1 = a clause break is needed before the candidate |

## Verification
The properties look only one cycle back. They assume that a clause built by a single scalar memory issue with a non-zero write bitmap is still intact in the next cycle, which is always so because only one issue can occur per cycle. They also assume that the issue class is meaningful whenever `issue_valid` is high. The stimulus drives every input at the falling edge, one issue per cycle at most, with 2'b11 used as a second "other" code. The bench's own model of the unions uses the same pre-issue ordering that R9 states.

// File: rtl/smem_clause_pkg.sv
package smem_clause_pkg;

    typedef enum logic [1:0] {
        CLS_NOP   = 2'b00,
        CLS_SMEM  = 2'b01,
        CLS_OTHA  = 2'b10,
        CLS_OTHB  = 2'b11
    } issue_cls_e;

endpackage

// File: rtl/smem_clause_sets.sv
module smem_clause_sets
    import smem_clause_pkg::*;
#(
    parameter int REG_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_valid,
    input  logic [1:0]       issue_cls,
    input  logic [REG_W-1:0] issue_rd,
    input  logic [REG_W-1:0] issue_wr,
    output logic [REG_W-1:0] clause_rd,
    output logic [REG_W-1:0] clause_wr
);

    typedef struct packed {
        logic [REG_W-1:0] rd;
        logic [REG_W-1:0] wr;
    } sets_t;

    sets_t sets_d, sets_q;
    logic  is_smem;

    // Next-state: extend on scalar memory, drop on anything else, hold when idle.
    always_comb begin
        sets_d  = sets_q;
        is_smem = (issue_cls == CLS_SMEM);
        if (issue_valid) begin
            if (is_smem) begin
                sets_d.rd = sets_q.rd | issue_rd;
                sets_d.wr = sets_q.wr | issue_wr;
            end else begin
                sets_d.rd = '0;
                sets_d.wr = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sets_q <= '0;
        end else begin
            sets_q <= sets_d;
        end
    end

    assign clause_rd = sets_q.rd;
    assign clause_wr = sets_q.wr;

endmodule

// File: rtl/smem_overlap_any.sv
module smem_overlap_any #(
    parameter int REG_W = 64,
    parameter int SEG_W = 16
) (
    input  logic [REG_W-1:0] set_a,
    input  logic [REG_W-1:0] set_b,
    output logic             hit
);

    localparam int NSEG = REG_W / SEG_W;

    logic [NSEG-1:0] seg_hit;

    // Balanced reduction: each segment ANDs and ORs locally, then segments are ORed.
    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        assign seg_hit[g] = |(set_a[g*SEG_W +: SEG_W] & set_b[g*SEG_W +: SEG_W]);
    end

    assign hit = |seg_hit;

endmodule

// File: rtl/smem_clause_breaker.sv
module smem_clause_breaker
    import smem_clause_pkg::*;
#(
    parameter int REG_W = 64,
    parameter int SEG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_new,
    input  logic             issue_valid,
    input  logic [1:0]       issue_cls,
    input  logic [REG_W-1:0] issue_rd,
    input  logic [REG_W-1:0] issue_wr,
    input  logic             cand_valid,
    input  logic             cand_store,
    input  logic [REG_W-1:0] cand_rd,
    input  logic [REG_W-1:0] cand_wr,
    output logic             brk_req
);

    typedef struct packed {
        logic brk;
    } dec_t;

    logic [REG_W-1:0] clause_rd, clause_wr;
    logic [REG_W-1:0] merged_rd, merged_wr;
    logic             overlap_hit;
    dec_t             dec_d, dec_q;

    smem_clause_sets #(
        .REG_W (REG_W)
    ) u_sets (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue_valid (issue_valid),
        .issue_cls   (issue_cls),
        .issue_rd    (issue_rd),
        .issue_wr    (issue_wr),
        .clause_rd   (clause_rd),
        .clause_wr   (clause_wr)
    );

    assign merged_rd = clause_rd | cand_rd;
    assign merged_wr = clause_wr | cand_wr;

    smem_overlap_any #(
        .REG_W (REG_W),
        .SEG_W (SEG_W)
    ) u_overlap (
        .set_a (merged_wr),
        .set_b (merged_rd),
        .hit   (overlap_hit)
    );

    // Decision uses the clause as it stood before any same-cycle issue.
    always_comb begin
        dec_d     = '0;
        dec_d.brk = cand_valid && mode_new && (|clause_wr) &&
                    (cand_store || overlap_hit);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q <= '0;
        end else begin
            dec_q <= dec_d;
        end
    end

    assign brk_req = dec_q.brk;

endmodule

// File: rtl/smem_clause_breaker_chk.sv
module smem_clause_breaker_chk
    import smem_clause_pkg::*;
#(
    parameter int REG_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_new,
    input logic             issue_valid,
    input logic [1:0]       issue_cls,
    input logic [REG_W-1:0] issue_wr,
    input logic             cand_valid,
    input logic             cand_store,
    input logic [REG_W-1:0] cand_rd,
    input logic [REG_W-1:0] cand_wr,
    input logic             brk_req
);

    assert_no_cand_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cand_valid |=> !brk_req);

    assert_mode_old_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_valid && !mode_new) |=> !brk_req);

    assert_clear_then_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_cls != CLS_SMEM) ##1 cand_valid |=> !brk_req);

    assert_store_breaks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_cls == CLS_SMEM && (|issue_wr))
        ##1 (cand_valid && cand_store && mode_new) |=> brk_req);

    assert_self_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_cls == CLS_SMEM && (|issue_wr))
        ##1 (cand_valid && mode_new && (|(cand_wr & cand_rd))) |=> brk_req);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_quiet_R1: assert (!brk_req || $past(rst_n));
        end
    end

endmodule

bind smem_clause_breaker smem_clause_breaker_chk #(
    .REG_W (REG_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_new    (mode_new),
    .issue_valid (issue_valid),
    .issue_cls   (issue_cls),
    .issue_wr    (issue_wr),
    .cand_valid  (cand_valid),
    .cand_store  (cand_store),
    .cand_rd     (cand_rd),
    .cand_wr     (cand_wr),
    .brk_req     (brk_req)
);

// File: tb/test_smem_clause_breaker.sv
module test_smem_clause_breaker;

    localparam int CLK_PERIOD = 10;
    localparam int W = 64;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mode_new = 1'b1;
    logic         issue_valid = 1'b0;
    logic [1:0]   issue_cls = 2'b00;
    logic [W-1:0] issue_rd = '0;
    logic [W-1:0] issue_wr = '0;
    logic         cand_valid = 1'b0;
    logic         cand_store = 1'b0;
    logic [W-1:0] cand_rd = '0;
    logic [W-1:0] cand_wr = '0;
    logic         brk_req;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    typedef struct {
        logic  exp;
        string tag;
    } item_t;

    item_t        sb[$];
    logic [W-1:0] mdl_rd = '0;
    logic [W-1:0] mdl_wr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    smem_clause_breaker i_smem_clause_breaker (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_new    (mode_new),
        .issue_valid (issue_valid),
        .issue_cls   (issue_cls),
        .issue_rd    (issue_rd),
        .issue_wr    (issue_wr),
        .cand_valid  (cand_valid),
        .cand_store  (cand_store),
        .cand_rd     (cand_rd),
        .cand_wr     (cand_wr),
        .brk_req     (brk_req)
    );

    function automatic logic [W-1:0] bitk(int k);
        return {{(W-1){1'b0}}, 1'b1} << k;
    endfunction

    // Driver: applies one cycle of stimulus and queues the answer expected after the edge.
    task automatic step(string tag, logic md, logic cv, logic cs,
                        logic [W-1:0] crd, logic [W-1:0] cwr,
                        logic iv, logic [1:0] ic,
                        logic [W-1:0] ird, logic [W-1:0] iwr);
        item_t it;
        @(negedge clk);
        mode_new = md;  cand_valid = cv; cand_store = cs;
        cand_rd = crd;  cand_wr = cwr;
        issue_valid = iv; issue_cls = ic; issue_rd = ird; issue_wr = iwr;
        it.exp = cv && md && (|mdl_wr) &&
                 (cs || (|((mdl_wr | cwr) & (mdl_rd | crd))));
        it.tag = tag;
        sb.push_back(it);
        if (iv) begin
            if (ic == 2'b01) begin
                mdl_rd = mdl_rd | ird;
                mdl_wr = mdl_wr | iwr;
            end else begin
                mdl_rd = '0;
                mdl_wr = '0;
            end
        end
    endtask

    // Monitor: compares one quarter period after each rising edge.
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (rst_n && sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            n_vec++;
            if (brk_req !== it.exp) begin
                n_bad++;
                $display("FAIL %s: brk_req actual=%b expected=%b", it.tag, brk_req, it.exp);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        n_vec++;
        if (brk_req !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 in reset: actual=%b expected=0", brk_req);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R1: empty clause after reset, even with self-overlapping candidate
        step("R1", 1, 1, 0, bitk(1), bitk(1), 0, 2'b00, '0, '0);
        // R2: build clause by scalar memory issue (wr r3, rd r1)
        step("R2", 1, 0, 0, '0, '0, 1, 2'b01, bitk(1), bitk(3));
        // R7: disjoint load
        step("R7", 1, 1, 0, bitk(5), bitk(6), 0, 2'b00, '0, '0);
        // R6: candidate reads clause-written r3
        step("R6", 1, 1, 0, bitk(3), '0, 0, 2'b00, '0, '0);
        // R6: candidate writes clause-read r1
        step("R6", 1, 1, 0, '0, bitk(1), 0, 2'b00, '0, '0);
        // R5: disjoint store still breaks
        step("R5", 1, 1, 1, bitk(40), '0, 0, 2'b00, '0, '0);
        // R8: old mode never breaks
        step("R8", 0, 1, 1, bitk(3), bitk(1), 0, 2'b00, '0, '0);
        // R10: idle cycles keep the clause
        step("R10", 1, 0, 0, '0, '0, 0, 2'b00, '0, '0);
        step("R10", 1, 1, 0, bitk(3), '0, 0, 2'b00, '0, '0);
        // R3: other-class issue clears, following overlap gives 0
        step("R3", 1, 0, 0, '0, '0, 1, 2'b10, '0, '0);
        step("R3", 1, 1, 0, bitk(3), bitk(1), 0, 2'b00, '0, '0);
        // R4: store against empty clause
        step("R4", 1, 1, 1, '0, '0, 0, 2'b00, '0, '0);
        // R4: read-only clause; candidate writes r10 that clause reads
        step("R4", 1, 0, 0, '0, '0, 1, 2'b01, bitk(10), '0);
        step("R4", 1, 1, 0, '0, bitk(10), 0, 2'b00, '0, '0);
        step("R4", 1, 1, 1, '0, '0, 0, 2'b00, '0, '0);
        // R6: clause member overlapping itself (r20), disjoint candidate
        step("R6", 1, 0, 0, '0, '0, 1, 2'b01, bitk(20), bitk(20));
        step("R6", 1, 1, 0, bitk(2), bitk(4), 0, 2'b00, '0, '0);
        // R3/R2: no-op clears
        step("R3", 1, 0, 0, '0, '0, 1, 2'b00, '0, '0);
        step("R3", 1, 1, 0, bitk(20), bitk(20), 0, 2'b00, '0, '0);
        // R6: boundary bits, clause writes r63, candidate self-overlaps r0
        step("R6", 1, 0, 0, '0, '0, 1, 2'b01, '0, bitk(63));
        step("R6", 1, 1, 0, bitk(0), bitk(0), 0, 2'b00, '0, '0);
        step("R6", 1, 1, 0, bitk(63), '0, 0, 2'b00, '0, '0);
        // R9: same-cycle issue (class 2'b11) does not affect candidate
        step("R9", 1, 1, 0, bitk(63), '0, 1, 2'b11, '0, '0);
        step("R9", 1, 1, 0, bitk(63), '0, 0, 2'b00, '0, '0);
        step("R9", 1, 1, 0, bitk(7), '0, 1, 2'b01, '0, bitk(7));
        step("R9", 1, 1, 0, bitk(7), '0, 0, 2'b00, '0, '0);
        // R9: no candidate, no break despite overlapping inputs
        step("R9", 1, 0, 1, bitk(7), bitk(7), 0, 2'b00, '0, '0);
        step("R9", 1, 0, 0, '0, '0, 0, 2'b00, '0, '0);

        @(posedge clk);
        #(CLK_PERIOD/2);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule